// File: doc/BRIEF.md
# Hex Record Stream Loader

This block turns a character stream of Intel HEX text into byte write requests for a memory that is being initialised. Characters arrive one per valid/ready handshake. For each record the block collects the fields, accumulates the byte checksum, and keeps two address bases: a segment base, shifted left by four, and a linear upper half-word. It acts on a record only after the record's checksum byte has passed. Data records are then issued as write requests, and each request carries a 32-bit absolute address and one data byte.

Both stream interfaces use valid/ready. An input character is consumed on a clock edge where `in_valid` and `in_ready` are both high. A write request is taken on an edge where `wr_valid` and `wr_ready` are both high. While a request is waiting, `wr_valid`, `wr_addr` and `wr_data` hold steady. `in_ready` stays low from the cycle after a data record's checksum is accepted until its last byte has been taken. The two start-address record kinds are captured into output registers. The end-of-file, checksum-error and format-error outputs are plain level flags that stay set until reset.

Top module: `ihex_loader`

## Requirements
- R1: A record starts with ':' (0x3A). In the idle state, CR (0x0D) and LF (0x0A) are skipped. Any other first character makes the block discard the line up to the next CR or LF, and that line produces no write and no error.
- R2: Hex digits 0-9, A-F and a-f are all accepted. Any other character inside a record sets `fmt_err`. The block then waits for the next ':' and parses the record that follows normally.
- R3: The byte count, both address bytes, the type, the data bytes and the checksum byte must add to a low byte of 0x00. If they do not, `cksum_err` is set and the record has no effect at all (no writes, no base or start change).
- R4: A type 0x00 record with n data bytes issues n writes in order. The i-th write goes to ({linear,16'h0} + {segment,4'h0} + record address + i), computed modulo 2^32. Writes are issued only after the checksum has passed.
- R5: A type 0x02 record (count 2) loads a segment value from its two data bytes, with the first byte as the most significant. Later data addresses include this value shifted left by 4. After reset the segment value is 0.
- R6: A type 0x04 record (count 2) loads the upper 16 address bits from its two data bytes, with the first byte as the most significant. After reset these bits are 0x0000.
- R7: A type 0x03 record (count 4) loads `start_cs_ip` with its four data bytes, the first in bits 31:24. A type 0x05 record (count 4) loads `start_linear` in the same way. Neither record writes to memory.
- R8: A type 0x01 record (count 0) sets `done`. After that, every character is accepted and ignored until reset, and no write is issued.
- R9: `fmt_err` is set by any of these: a type above 0x05, a count that does not match types 0x01 to 0x05, or a type 0x00 count above BUF_DEPTH (default 32).
- R10: While a write is pending, `in_ready` is low. A stalled write holds its address and data stable.
- R11: After reset, `in_ready` is 1, and `wr_valid`, `done`, `cksum_err` and `fmt_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input character valid |
| in_data | input | 8 | ASCII character |
| in_ready | output | 1 | Block can accept a character |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Absolute byte address |
| wr_data | output | 8 | Byte to write |
| done | output | 1 | End-of-file record seen |
| cksum_err | output | 1 | A record failed its checksum (sticky) |
| fmt_err | output | 1 | A malformed record was seen (sticky) |
| start_cs_ip | output | 32 | Last type 0x03 start address |
| start_linear | output | 32 | Last type 0x05 start address |

## Verification
The flags, bases and start registers change on the clock edge that consumes the checksum character, so they are valid by the next falling edge. The first write request appears two edges after that character is consumed, and each later request appears one edge after the previous one is taken. The bench therefore logs writes at each rising edge where the handshake completes. It reads flags and start registers only after a record's trailing CR and LF have been consumed and several idle cycles have passed. Inputs are driven at falling edges, and a write stall pattern is used to exercise back-pressure.

// File: rtl/ihex_pkg.sv
package ihex_pkg;
  typedef enum logic [2:0] {
    PS_LINE, PS_SKIP, PS_HUNT, PS_REC, PS_DONE
  } pstate_t;

  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  function automatic logic rec_legal(input logic [7:0] t, input logic [7:0] c,
                                     input int depth);
    case (t)
      8'h00:        return int'(c) <= depth;
      8'h01:        return c == 8'd0;
      8'h02, 8'h04: return c == 8'd2;
      8'h03, 8'h05: return c == 8'd4;
      default:      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ihex_hexdig.sv
module ihex_hexdig (
  input  logic [7:0] ch,
  output logic       is_hex,
  output logic [3:0] val
);
  always_comb begin
    is_hex = 1'b1;
    val    = 4'h0;
    if (ch >= 8'h30 && ch <= 8'h39)      val = 4'(ch - 8'h30);
    else if (ch >= 8'h41 && ch <= 8'h46) val = 4'(ch - 8'h37);
    else if (ch >= 8'h61 && ch <= 8'h66) val = 4'(ch - 8'h57);
    else                                 is_hex = 1'b0;
  end
endmodule

// File: rtl/ihex_rec_parser.sv
module ihex_rec_parser
  import ihex_pkg::*;
#(
  parameter int BUF_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic        drain_busy,
  output logic        launch,
  output logic [7:0]  launch_cnt,
  output logic [31:0] launch_base,
  input  logic [7:0]  rd_idx,
  output logic [7:0]  rd_data,
  output logic        done,
  output logic        cksum_err,
  output logic        fmt_err,
  output logic [31:0] start_cs_ip,
  output logic [31:0] start_linear
);
  localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

  pstate_t     st;
  logic        have_hi;
  logic [3:0]  nib_hi;
  logic [8:0]  idx;
  logic [7:0]  cnt, rtype, sum;
  logic [15:0] raddr, seg, lin;
  logic [7:0]  bufm [BUF_DEPTH];

  logic        acc, is_hex, eol, colon;
  logic [3:0]  nval;
  logic [7:0]  bval, sum_n;
  logic [8:0]  data_pos;
  logic        buf_we;

  ihex_hexdig u_dig (.ch(in_data), .is_hex(is_hex), .val(nval));

  assign in_ready = !drain_busy;
  assign acc      = in_valid && in_ready;
  assign eol      = (in_data == CH_CR) || (in_data == CH_LF);
  assign colon    = (in_data == CH_COLON);
  assign bval     = {nib_hi, nval};
  assign sum_n    = sum + bval;
  assign data_pos = idx - 9'd4;
  assign buf_we   = acc && st == PS_REC && is_hex && have_hi && idx >= 9'd4 &&
                    data_pos < {1'b0, cnt};
  assign rd_data  = bufm[rd_idx[AW-1:0]];
  assign done     = (st == PS_DONE);

  always_ff @(posedge clk)
    if (buf_we) bufm[data_pos[AW-1:0]] <= bval;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PS_LINE; have_hi <= 1'b0; nib_hi <= '0; idx <= '0;
      cnt <= '0; rtype <= '0; sum <= '0; raddr <= '0; seg <= '0; lin <= '0;
      cksum_err <= 1'b0; fmt_err <= 1'b0;
      start_cs_ip <= '0; start_linear <= '0;
      launch <= 1'b0; launch_cnt <= '0; launch_base <= '0;
    end else begin
      launch <= 1'b0;
      if (acc) begin
        case (st)
          PS_LINE: begin
            if (colon) begin
              st <= PS_REC; idx <= '0; have_hi <= 1'b0; sum <= '0;
            end else if (!eol) st <= PS_SKIP;
          end
          PS_SKIP: if (eol) st <= PS_LINE;
          PS_HUNT: if (colon) begin
            st <= PS_REC; idx <= '0; have_hi <= 1'b0; sum <= '0;
          end
          PS_REC: begin
            if (!is_hex) begin
              fmt_err <= 1'b1;
              idx <= '0; have_hi <= 1'b0; sum <= '0;
              st <= colon ? PS_REC : PS_HUNT;
            end else if (!have_hi) begin
              nib_hi <= nval; have_hi <= 1'b1;
            end else begin
              have_hi <= 1'b0;
              sum <= sum_n;
              idx <= idx + 9'd1;
              case (idx)
                9'd0: cnt <= bval;
                9'd1: raddr[15:8] <= bval;
                9'd2: raddr[7:0] <= bval;
                9'd3: begin
                  rtype <= bval;
                  if (!rec_legal(bval, cnt, BUF_DEPTH)) begin
                    fmt_err <= 1'b1; st <= PS_HUNT;
                  end
                end
                default: if (data_pos >= {1'b0, cnt}) begin
                  st <= PS_LINE;
                  if (sum_n != 8'h00) cksum_err <= 1'b1;
                  else case (rtype)
                    8'h00: if (cnt != 8'd0) begin
                      launch <= 1'b1; launch_cnt <= cnt;
                      launch_base <= {lin, 16'h0000} + {12'h000, seg, 4'h0} +
                                     {16'h0000, raddr};
                    end
                    8'h01: st <= PS_DONE;
                    8'h02: seg <= {bufm[0], bufm[1]};
                    8'h03: start_cs_ip <= {bufm[0], bufm[1], bufm[2], bufm[3]};
                    8'h04: lin <= {bufm[0], bufm[1]};
                    default: start_linear <= {bufm[0], bufm[1], bufm[2], bufm[3]};
                  endcase
                end
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_cksum_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_err |=> cksum_err);
  assert_fmt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);
  assert_no_launch_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !launch);
endmodule

// File: rtl/ihex_wr_drain.sv
module ihex_wr_drain #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    start_cnt,
  input  logic [AW-1:0] start_base,
  output logic          busy,
  output logic [7:0]    rd_idx,
  input  logic [7:0]    rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  logic          active;
  logic [7:0]    ptr, cnt_q;
  logic [AW-1:0] base_q;

  assign busy     = start || active;
  assign rd_idx   = ptr;
  assign wr_valid = active;
  assign wr_addr  = base_q + AW'(ptr);
  assign wr_data  = rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; ptr <= '0; cnt_q <= '0; base_q <= '0;
    end else if (start) begin
      active <= 1'b1; ptr <= '0; cnt_q <= start_cnt; base_q <= start_base;
    end else if (active && wr_ready) begin
      if (ptr == cnt_q - 8'd1) active <= 1'b0;
      else                     ptr <= ptr + 8'd1;
    end
  end

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (ptr < cnt_q));
endmodule

// File: rtl/ihex_loader.sv
module ihex_loader #(
  parameter int BUF_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        done,
  output logic        cksum_err,
  output logic        fmt_err,
  output logic [31:0] start_cs_ip,
  output logic [31:0] start_linear
);
  logic        busy, launch;
  logic [7:0]  launch_cnt, rd_idx, rd_data;
  logic [31:0] launch_base;

  ihex_rec_parser #(.BUF_DEPTH(BUF_DEPTH)) u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .drain_busy(busy), .launch(launch),
    .launch_cnt(launch_cnt), .launch_base(launch_base), .rd_idx(rd_idx),
    .rd_data(rd_data), .done(done), .cksum_err(cksum_err), .fmt_err(fmt_err),
    .start_cs_ip(start_cs_ip), .start_linear(start_linear));

  ihex_wr_drain #(.AW(32)) u_drain (
    .clk(clk), .rst_n(rst_n), .start(launch), .start_cnt(launch_cnt),
    .start_base(launch_base), .busy(busy), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

  assert_no_input_while_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !in_ready);
  assert_done_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);
endmodule

// File: tb/sim_ihex_loader.sv
module sim_ihex_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0, wr_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, wr_valid, done, cksum_err, fmt_err;
  logic [31:0] wr_addr, start_cs_ip, start_linear;
  logic [7:0] wr_data;

  int checks = 0, failures = 0, nw = 0, bp_viol = 0, stall_cnt = 0;
  bit stall_en = 0, finished = 0;
  logic [31:0] wa [0:63];
  logic [7:0]  wd [0:63];
  logic [7:0]  dbuf [0:35];

  always #(CLK_PERIOD/2) clk = ~clk;

  ihex_loader u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .cksum_err(cksum_err), .fmt_err(fmt_err),
    .start_cs_ip(start_cs_ip), .start_linear(start_linear));

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready && nw < 64) begin
      wa[nw] <= wr_addr; wd[nw] <= wr_data; nw <= nw + 1;
    end
    if (rst_n && wr_valid && in_ready) bp_viol <= bp_viol + 1;
  end

  always @(negedge clk) begin
    stall_cnt <= stall_cnt + 1;
    wr_ready  <= !stall_en || (stall_cnt % 3 == 0);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; nw = 0; bp_viol = 0;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] c);
    in_valid = 1; in_data = c;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [7:0] hch(input logic [3:0] n, input bit low);
    if (n < 10) return 8'h30 + 8'(n);
    return (low ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
  endfunction

  task automatic put_byte(input logic [7:0] b, input bit low);
    put(hch(b[7:4], low)); put(hch(b[3:0], low));
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    while (wr_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_rec(input logic [7:0] c, input logic [15:0] a,
                          input logic [7:0] t, input bit bad_ck, input bit low);
    logic [7:0] s;
    s = c + a[15:8] + a[7:0] + t;
    put(8'h3A);
    put_byte(c, low); put_byte(a[15:8], low); put_byte(a[7:0], low); put_byte(t, low);
    for (int i = 0; i < int'(c) && i < 36; i++) begin
      put_byte(dbuf[i], low); s = s + dbuf[i];
    end
    s = 8'h00 - s;
    if (bad_ck) s = s + 8'h01;
    put_byte(s, low);
    put(8'h0D); put(8'h0A);
    settle();
  endtask

  task automatic t_reset();
    do_reset();
    chk(in_ready == 1, "R11 in_ready", in_ready, 1);
    chk(!wr_valid && !done && !cksum_err && !fmt_err, "R11 flags",
        {wr_valid, done, cksum_err, fmt_err}, 0);
  endtask

  task automatic t_data();
    do_reset();
    stall_en = 1;
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33; dbuf[3] = 8'h44;
    send_rec(8'd4, 16'h0100, 8'h00, 0, 0);
    stall_en = 0;
    chk(nw == 4, "R4 write count", nw, 4);
    for (int i = 0; i < 4; i++) begin
      chk(wa[i] == 32'h100 + i, "R4 address", wa[i], 32'h100 + i);
      chk(wd[i] == dbuf[i], "R4 data", wd[i], dbuf[i]);
    end
    chk(bp_viol == 0, "R10 in_ready low while write pending", bp_viol, 0);
    chk(!cksum_err && !fmt_err, "R3 no error on good record", {cksum_err, fmt_err}, 0);
  endtask

  task automatic t_lower();
    do_reset();
    dbuf[0] = 8'hAB; dbuf[1] = 8'hCD;
    send_rec(8'd2, 16'h0A0E, 8'h00, 0, 1);
    chk(nw == 2 && wa[0] == 32'h0A0E && wd[0] == 8'hAB && wd[1] == 8'hCD,
        "R2 lowercase digits", {wd[0], wd[1]}, 16'hABCD);
    chk(!fmt_err, "R2 no fmt_err", fmt_err, 0);
  endtask

  task automatic t_cksum();
    do_reset();
    dbuf[0] = 8'h12; dbuf[1] = 8'h00;
    send_rec(8'd2, 16'h0000, 8'h02, 1, 0);
    dbuf[0] = 8'h55;
    send_rec(8'd1, 16'h0020, 8'h00, 1, 0);
    chk(cksum_err == 1, "R3 cksum_err", cksum_err, 1);
    chk(nw == 0, "R3 no writes", nw, 0);
    chk(!fmt_err, "R3 no fmt_err", fmt_err, 0);
    send_rec(8'd1, 16'h0020, 8'h00, 0, 0);
    chk(nw == 1 && wa[0] == 32'h20, "R3 failed segment not applied", wa[0], 32'h20);
  endtask

  task automatic t_segment();
    do_reset();
    dbuf[0] = 8'h12; dbuf[1] = 8'h00;
    send_rec(8'd2, 16'h0000, 8'h02, 0, 0);
    dbuf[0] = 8'hAA; dbuf[1] = 8'hBB;
    send_rec(8'd2, 16'h0010, 8'h00, 0, 0);
    chk(nw == 2 && wa[0] == 32'h12010 && wa[1] == 32'h12011, "R5 segment address",
        wa[1], 32'h12011);
  endtask

  task automatic t_linear();
    do_reset();
    dbuf[0] = 8'h08; dbuf[1] = 8'h00;
    send_rec(8'd2, 16'h0000, 8'h04, 0, 0);
    dbuf[0] = 8'h5A; dbuf[1] = 8'hA5;
    send_rec(8'd2, 16'hFFFF, 8'h00, 0, 0);
    chk(nw == 2 && wa[0] == 32'h0800FFFF, "R6 linear base", wa[0], 32'h0800FFFF);
    chk(wa[1] == 32'h08010000, "R4 address carry", wa[1], 32'h08010000);
    dbuf[0] = 8'h01; dbuf[1] = 8'h00;
    send_rec(8'd2, 16'h0000, 8'h02, 0, 0);
    dbuf[0] = 8'h77;
    send_rec(8'd1, 16'h0002, 8'h00, 0, 0);
    chk(nw == 3 && wa[2] == 32'h08001002, "R5 segment plus linear", wa[2], 32'h08001002);
  endtask

  task automatic t_start();
    do_reset();
    dbuf[0] = 8'h12; dbuf[1] = 8'h34; dbuf[2] = 8'h56; dbuf[3] = 8'h78;
    send_rec(8'd4, 16'h0000, 8'h03, 0, 0);
    dbuf[0] = 8'hDE; dbuf[1] = 8'hAD; dbuf[2] = 8'hBE; dbuf[3] = 8'hEF;
    send_rec(8'd4, 16'h0000, 8'h05, 0, 0);
    chk(start_cs_ip == 32'h12345678, "R7 start_cs_ip", start_cs_ip, 32'h12345678);
    chk(start_linear == 32'hDEADBEEF, "R7 start_linear", start_linear, 32'hDEADBEEF);
    chk(nw == 0, "R7 no writes", nw, 0);
  endtask

  task automatic t_junk();
    do_reset();
    put("x"); put("y"); put(":"); put("1"); put(8'h0D); put(8'h0A);
    dbuf[0] = 8'h3C;
    send_rec(8'd1, 16'h0040, 8'h00, 0, 0);
    chk(!fmt_err && !cksum_err, "R1 junk line no error", {fmt_err, cksum_err}, 0);
    chk(nw == 1 && wa[0] == 32'h40 && wd[0] == 8'h3C, "R1 junk line no write", nw, 1);
  endtask

  task automatic t_badchar();
    do_reset();
    put(":"); put("0"); put("G"); put("1"); put("2");
    settle();
    chk(fmt_err == 1, "R2 non-hex sets fmt_err", fmt_err, 1);
    chk(nw == 0, "R2 no write from bad record", nw, 0);
    dbuf[0] = 8'h99;
    send_rec(8'd1, 16'h0005, 8'h00, 0, 0);
    chk(nw == 1 && wa[0] == 32'h5 && wd[0] == 8'h99, "R2 resync at colon", wd[0], 8'h99);
  endtask

  task automatic t_fmt();
    do_reset();
    send_rec(8'd0, 16'h0000, 8'h06, 0, 0);
    chk(fmt_err == 1, "R9 type 06", fmt_err, 1);
    do_reset();
    dbuf[0] = 8'h10;
    send_rec(8'd1, 16'h0000, 8'h02, 0, 0);
    chk(fmt_err == 1, "R9 type 02 count 1", fmt_err, 1);
    do_reset();
    for (int i = 0; i < 36; i++) dbuf[i] = 8'(i);
    send_rec(8'd33, 16'h0000, 8'h00, 0, 0);
    chk(fmt_err == 1 && nw == 0, "R9 count over depth", {fmt_err, 8'(nw)}, 9'h100);
  endtask

  task automatic t_eof();
    do_reset();
    send_rec(8'd0, 16'h0000, 8'h01, 0, 0);
    chk(done == 1, "R8 done set", done, 1);
    dbuf[0] = 8'h42;
    send_rec(8'd1, 16'h0000, 8'h00, 0, 0);
    put("Z");
    settle();
    chk(done == 1 && nw == 0, "R8 ignored after done", nw, 0);
    chk(in_ready == 1 && !fmt_err, "R8 in_ready high, no error", {in_ready, fmt_err}, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 36; i++) dbuf[i] = 0;
    t_reset();
    t_data();
    t_lower();
    t_cksum();
    t_segment();
    t_linear();
    t_start();
    t_junk();
    t_badchar();
    t_fmt();
    t_eof();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule